// File: doc/BRIEF.md
# AFE Serial Receiver and Decimator

This block is the first stage of a receive front-end. An analog converter delivers 16-bit samples over a 4-bit link, and each sample takes four clock cycles to cross it. The block rebuilds each word from its four nibbles. It then lowers the sample rate by four with a symmetric low-pass FIR whose taps software can program. The arithmetic saturates and rounds the result back to 16 bits. Line samples arrive at the 8.8 MHz rate, and filtered samples leave at 2.2 MHz.

A source selector replaces the rebuilt line samples with a looped-back transmit stream, for use in test. A bypass control sends every selected sample straight to the output without filtering. While bypass is set, the filter history and the decimation phase do not change.

The sample path runs at a fixed rate and has no back-pressure. The link pushes one nibble per cycle and cannot be stalled. The loopback source and the output both use a single-cycle valid qualifier and have no ready signal. A consumer must take each `out_valid` pulse in the cycle it appears, because a result is never held or repeated.

Top module: `afe_rx_decim`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0. Reset clears the filter history to zero, sets the decimation phase to 0 and clears all coefficients to 0, so the first decimated result after reset is 0.
- R2: A high `afe_frame` marks the first nibble of a word. That nibble and the nibbles on the next three cycles form the word, most significant nibble first: bits 15:12, then 11:8, 7:4, 3:0. The rebuilt word is valid one cycle after the fourth nibble is sampled.
- R3: A frame strobe that arrives before a word is complete discards the partial word and starts a new one. Nibbles that arrive while no word is in progress and `afe_frame` is low are ignored.
- R4: With `lpbk_sel`=1, the samples come from `lpbk_valid`/`lpbk_data` and the link produces no samples. With `lpbk_sel`=0, the link is the source and the loopback inputs have no effect.
- R5: `out_valid` is high only in the cycle after a selected sample was accepted.
- R6: With `bypass`=0, exactly one result is produced for every 4 accepted samples. It appears one cycle after the 4th, 8th, 12th and later samples counted from reset.
- R7: The filter has 8 taps and is symmetric. Coefficient k (k=0..3) weights both x[n-k] and x[n-7+k]. Coefficients are signed 16-bit values with 14 fractional bits. The sum is rounded half-up by adding 2^13 and then shifted arithmetically right by 14.
- R8: A rounded result above 32767 is output as 32767, and a result below -32768 is output as -32768.
- R9: With `bypass`=1, each accepted sample appears unchanged on `out_data` with `out_valid` high one cycle later. The filter history and the decimation phase keep their values.
- R10: When `coef_we` is high, `coef_data` is written into coefficient `coef_addr` (0..3) at the clock edge. Every result computed after that edge uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| afe_frame | input | 1 | High on the first nibble of each word |
| afe_nib | input | 4 | Serial link nibble |
| lpbk_sel | input | 1 | 1 selects the loopback source |
| lpbk_valid | input | 1 | Loopback sample qualifier |
| lpbk_data | input | 16 | Loopback sample, signed |
| bypass | input | 1 | 1 sends samples through without filtering |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 2 | Coefficient index |
| coef_data | input | 16 | Coefficient value, signed Q1.14 |
| out_valid | output | 1 | Result qualifier, one cycle wide |
| out_data | output | 16 | Result sample, signed |

## Verification
A loopback sample produces its result one cycle after it is accepted. A link word produces its result two cycles after its fourth nibble: one register rebuilds the word and a second register holds the output. The bench collects every `out_valid` pulse on the falling clock edge and compares the collected list with a list computed from a bench-side filter model. This makes the value checks independent of exact alignment. The one-cycle bypass latency is checked directly, one edge after the drive. The checker asserts the exact cycle of each result against its own count of accepted samples.

// File: rtl/afe_rx_pkg.sv
package afe_rx_pkg;
  localparam int SAMPLE_W = 16;
  localparam int NIBBLE_W = 4;
  localparam int COEF_W   = 16;
  localparam int COEF_FRAC = 14;

  typedef enum logic {SRC_LINK = 1'b0, SRC_LOOP = 1'b1} src_e;
endpackage

// File: rtl/afe_nibble_deser.sv
module afe_nibble_deser #(
  parameter int W   = 16,
  parameter int NW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame,
  input  logic [NW-1:0] nib,
  output logic          word_valid,
  output logic [W-1:0]  word
);
  localparam int NNIB = W / NW;
  localparam int CNTW = (NNIB > 2) ? $clog2(NNIB) : 1;
  localparam int SHW  = W - NW;

  logic [SHW-1:0]  sh;
  logic [CNTW-1:0] cnt;
  logic            busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh <= '0;
      cnt <= '0;
      busy <= 1'b0;
      word_valid <= 1'b0;
      word <= '0;
    end else begin
      word_valid <= 1'b0;
      if (frame) begin
        sh   <= SHW'(nib);
        cnt  <= CNTW'(1);
        busy <= 1'b1;
      end else if (busy) begin
        if (cnt == CNTW'(NNIB - 1)) begin
          word       <= {sh, nib};
          word_valid <= 1'b1;
          busy       <= 1'b0;
          cnt        <= '0;
        end else begin
          sh  <= {sh[SHW-NW-1:0], nib};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/afe_coef_bank.sv
module afe_coef_bank #(
  parameter int NUNIQ = 4,
  parameter int CW    = 16,
  localparam int CAW  = (NUNIQ > 1) ? $clog2(NUNIQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [CAW-1:0]        addr,
  input  logic [CW-1:0]         wdata,
  output logic [NUNIQ*CW-1:0]   coef_flat
);
  for (genvar k = 0; k < NUNIQ; k++) begin : g_coef
    always_ff @(posedge clk) begin
      if (!rst_n)
        coef_flat[k*CW +: CW] <= '0;
      else if (we && addr == CAW'(k))
        coef_flat[k*CW +: CW] <= wdata;
    end
  end
endmodule

// File: rtl/afe_decim_fir.sv
module afe_decim_fir #(
  parameter int W     = 16,
  parameter int NTAPS = 8,
  parameter int DEC   = 4,
  parameter int CW    = 16,
  parameter int FRAC  = 14
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [W-1:0]               in_data,
  input  logic                       bypass,
  input  logic [(NTAPS/2)*CW-1:0]    coef_flat,
  output logic                       out_valid,
  output logic [W-1:0]               out_data
);
  localparam int NUNIQ = NTAPS / 2;
  localparam int PW    = W + 1 + CW;
  localparam int AW    = PW + $clog2(NUNIQ) + 1;
  localparam int PHW   = (DEC > 2) ? $clog2(DEC) : 1;
  localparam logic signed [AW-1:0] RHALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] SMAX  = AW'((2 ** (W - 1)) - 1);
  localparam logic signed [AW-1:0] SMIN  = -SMAX - AW'(1);

  logic signed [W-1:0]  hist [NTAPS-1];
  logic signed [W-1:0]  tap  [NTAPS];
  logic signed [PW-1:0] prod [NUNIQ];
  logic signed [AW-1:0] acc, rnd;
  logic [W-1:0]         sat_y;
  logic [PHW-1:0]       phase;

  always_comb begin
    tap[0] = in_data;
    for (int k = 1; k < NTAPS; k++) tap[k] = hist[k-1];
  end

  for (genvar k = 0; k < NUNIQ; k++) begin : g_pair
    logic signed [CW-1:0] ck;
    logic signed [W:0]    pre;
    assign ck      = coef_flat[k*CW +: CW];
    assign pre     = (W+1)'(tap[k]) + (W+1)'(tap[NTAPS-1-k]);
    assign prod[k] = PW'(pre) * PW'(ck);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NUNIQ; k++) acc = acc + AW'(prod[k]);
    rnd = (acc + RHALF) >>> FRAC;
    if (rnd > SMAX)      sat_y = SMAX[W-1:0];
    else if (rnd < SMIN) sat_y = SMIN[W-1:0];
    else                 sat_y = rnd[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      phase     <= '0;
      for (int k = 0; k < NTAPS-1; k++) hist[k] <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid) begin
        if (bypass) begin
          out_valid <= 1'b1;
          out_data  <= in_data;
        end else begin
          for (int k = 0; k < NTAPS-1; k++) hist[k] <= tap[k];
          if (phase == PHW'(DEC - 1)) begin
            phase     <= '0;
            out_valid <= 1'b1;
            out_data  <= sat_y;
          end else begin
            phase <= phase + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/afe_rx_decim.sv
module afe_rx_decim
  import afe_rx_pkg::*;
#(
  parameter int W     = SAMPLE_W,
  parameter int NW    = NIBBLE_W,
  parameter int NTAPS = 8,
  parameter int DEC   = 4,
  parameter int CW    = COEF_W,
  parameter int FRAC  = COEF_FRAC,
  localparam int CAW  = (NTAPS/2 > 1) ? $clog2(NTAPS/2) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           afe_frame,
  input  logic [NW-1:0]  afe_nib,
  input  logic           lpbk_sel,
  input  logic           lpbk_valid,
  input  logic [W-1:0]   lpbk_data,
  input  logic           bypass,
  input  logic           coef_we,
  input  logic [CAW-1:0] coef_addr,
  input  logic [CW-1:0]  coef_data,
  output logic           out_valid,
  output logic [W-1:0]   out_data
);
  localparam int NUNIQ = NTAPS / 2;

  logic                word_valid;
  logic [W-1:0]        word;
  logic                smp_valid;
  logic [W-1:0]        smp_data;
  logic [NUNIQ*CW-1:0] coef_flat;
  src_e                src;

  afe_nibble_deser #(.W(W), .NW(NW)) u_deser (
    .clk(clk), .rst_n(rst_n), .frame(afe_frame), .nib(afe_nib),
    .word_valid(word_valid), .word(word)
  );

  assign src       = lpbk_sel ? SRC_LOOP : SRC_LINK;
  assign smp_valid = (src == SRC_LOOP) ? lpbk_valid : word_valid;
  assign smp_data  = (src == SRC_LOOP) ? lpbk_data  : word;

  afe_coef_bank #(.NUNIQ(NUNIQ), .CW(CW)) u_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .addr(coef_addr),
    .wdata(coef_data), .coef_flat(coef_flat)
  );

  afe_decim_fir #(.W(W), .NTAPS(NTAPS), .DEC(DEC), .CW(CW), .FRAC(FRAC)) u_fir (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_data(smp_data),
    .bypass(bypass), .coef_flat(coef_flat),
    .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/afe_rx_decim_chk.sv
module afe_rx_decim_chk #(
  parameter int W   = 16,
  parameter int DEC = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         afe_frame,
  input logic         word_valid,
  input logic         smp_valid,
  input logic [W-1:0] smp_data,
  input logic         bypass,
  input logic         out_valid,
  input logic [W-1:0] out_data
);
  localparam int PHW = (DEC > 2) ? $clog2(DEC) : 1;
  logic [PHW-1:0] seen;

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (smp_valid && !bypass)
      seen <= (seen == PHW'(DEC - 1)) ? '0 : seen + 1'b1;
  end

  // R3: a frame strobe never completes a word on the next edge
  a_r3_frame_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    afe_frame |=> !word_valid);

  // R5: every result follows an accepted sample
  a_r5_out_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(smp_valid));

  // R9: bypass passes the sample unchanged one cycle later
  a_r9_bypass_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass && smp_valid) |=> (out_valid && out_data == $past(smp_data)));

  // R6: the last sample of a group of DEC yields a result
  a_r6_decim_fire: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && smp_valid && seen == PHW'(DEC - 1)) |=> out_valid);

  // R6: other samples of the group yield none
  a_r6_decim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!bypass && smp_valid && seen != PHW'(DEC - 1)) |=> !out_valid);
endmodule

bind afe_rx_decim afe_rx_decim_chk #(.W(W), .DEC(DEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .afe_frame(afe_frame), .word_valid(word_valid),
  .smp_valid(smp_valid), .smp_data(smp_data), .bypass(bypass),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_afe_rx_decim.sv
`timescale 1ns/1ps
module sim_afe_rx_decim;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        afe_frame = 1'b0;
  logic [3:0]  afe_nib = '0;
  logic        lpbk_sel = 1'b0;
  logic        lpbk_valid = 1'b0;
  logic [15:0] lpbk_data = '0;
  logic        bypass = 1'b0;
  logic        coef_we = 1'b0;
  logic [1:0]  coef_addr = '0;
  logic [15:0] coef_data = '0;
  logic        out_valid;
  logic [15:0] out_data;

  always #2.5 clk = ~clk;

  afe_rx_decim u0 (.*);

  localparam int NV = 16;
  localparam logic signed [15:0] VEC [NV] = '{
    16'sd100, -16'sd200, 16'sd3000, 16'sd12000, -16'sd15000, 16'sd32767,
    -16'sd32768, 16'sd500, 16'sd7, -16'sd7, 16'sd20000, -16'sd20000,
    16'sd0, 16'sd1234, -16'sd4321, 16'sd16384};

  int nchk = 0, nfail = 0, ngot = 0, nexp = 0;
  int got [64];
  int expv [64];
  int mh [8];
  int mc [4];
  int mph = 0;
  bit done = 0;

  always @(negedge clk)
    if (rst_n && out_valid && ngot < 64) begin
      got[ngot] = int'($signed(out_data));
      ngot++;
    end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_push(input int x);
    longint acc;
    int y;
    if (bypass) return;
    acc = 0;
    for (int k = 7; k > 0; k--) mh[k] = mh[k-1];
    mh[0] = x;
    if (mph == 3) begin
      for (int k = 0; k < 4; k++) acc += longint'(mc[k]) * longint'(mh[k] + mh[7-k]);
      acc = (acc + 8192) >>> 14;
      if (acc > 32767) y = 32767;
      else if (acc < -32768) y = -32768;
      else y = int'(acc);
      if (nexp < 64) expv[nexp] = y;
      nexp++;
      mph = 0;
    end else mph++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; afe_frame = 0; lpbk_valid = 0; coef_we = 0; bypass = 0;
    repeat (2) @(negedge clk);
    chk("R1 out_valid in reset", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int k = 0; k < 8; k++) mh[k] = 0;
    for (int k = 0; k < 4; k++) mc[k] = 0;
    mph = 0; ngot = 0; nexp = 0;
  endtask

  task automatic set_coef(input int a, input int v);
    @(negedge clk);
    coef_we = 1; coef_addr = 2'(a); coef_data = 16'(v);
    @(negedge clk);
    coef_we = 0;
    mc[a] = v;
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      afe_frame = (i == 0);
      afe_nib = w[15-4*i -: 4];
    end
    model_push(int'($signed(w)));
  endtask

  task automatic send_lb(input logic [15:0] d);
    @(negedge clk);
    lpbk_valid = 1; lpbk_data = d;
    model_push(int'($signed(d)));
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    afe_frame = 0; afe_nib = 4'h0; lpbk_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clear();
    ngot = 0; nexp = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R1: zero coefficients after reset give a zero first result
    do_reset();
    chk("R1 out_valid after release", int'(out_valid), 0);
    for (int i = 0; i < 4; i++) send_word(16'd1000);
    idle(4);
    chk("R1 one result", ngot, 1);
    chk("R1 zero coefficients", got[0], 0);

    // R10: program taps, then walk the vector table through the link
    set_coef(0, 1024); set_coef(1, 2048); set_coef(2, 4096); set_coef(3, 8192);
    clear();
    for (int i = 0; i < NV; i++) send_word(VEC[i]);
    idle(4);
    chk("R6 results per 16 samples", ngot, nexp);
    for (int i = 0; i < 4; i++) chk("R7 R10 filtered value", got[i], expv[i]);

    // R8: saturation, fed from loopback (R4)
    lpbk_sel = 1;
    clear();
    for (int i = 0; i < 8; i++) send_lb(16'h7FFF);
    idle(2);
    chk("R8 positive count", ngot, 2);
    chk("R8 positive model", got[0], expv[0]);
    chk("R8 positive clamp", got[1], 32767);
    clear();
    for (int i = 0; i < 8; i++) send_lb(16'h8000);
    idle(2);
    chk("R8 negative model", got[0], expv[0]);
    chk("R8 negative clamp", got[1], -32768);

    // R7: half-up rounding with a single centre pair
    do_reset();
    set_coef(3, 8192);
    lpbk_sel = 1;
    for (int i = 0; i < 4; i++) send_lb(16'd2);
    for (int i = 0; i < 4; i++) send_lb(16'd5);
    for (int i = 0; i < 4; i++) send_lb(-16'sd2);
    for (int i = 0; i < 4; i++) send_lb(-16'sd5);
    idle(2);
    chk("R7 round count", ngot, 4);
    chk("R7 round 3.5", got[1], 4);
    chk("R7 round 1.5", got[2], 2);
    chk("R7 round -3.5", got[3], -3);

    // R9: bypass leaves history and phase untouched
    do_reset();
    set_coef(3, 8192);
    lpbk_sel = 1;
    send_lb(16'd4); send_lb(16'd4);
    idle(1);
    bypass = 1;
    send_lb(16'd1000); send_lb(16'd2000); send_lb(16'd3000);
    idle(1);
    bypass = 0;
    send_lb(16'd4); send_lb(16'd4);
    idle(2);
    chk("R9 count", ngot, 4);
    chk("R9 pass 1", got[0], 1000);
    chk("R9 pass 3", got[2], 3000);
    chk("R9 frozen filter", got[3], 2);

    // R9 and R5: one-cycle latency and a single pulse
    bypass = 1;
    @(negedge clk); lpbk_valid = 1; lpbk_data = 16'd777;
    @(posedge clk); #1;
    chk("R9 latency valid", int'(out_valid), 1);
    chk("R9 latency data", int'(out_data), 777);
    @(negedge clk); lpbk_valid = 0;
    @(posedge clk); #1;
    chk("R5 no pulse without sample", int'(out_valid), 0);

    // R2: nibble order through the link
    lpbk_sel = 0;
    idle(1);
    clear();
    send_word(16'hA5C3);
    idle(3);
    chk("R2 word count", ngot, 1);
    chk("R2 msb first", got[0], int'($signed(16'hA5C3)));

    // R3: interrupted word, then stray nibbles
    clear();
    @(negedge clk); afe_frame = 1; afe_nib = 4'hF;
    @(negedge clk); afe_frame = 0; afe_nib = 4'hE;
    send_word(16'h1234);
    idle(3);
    chk("R3 restart count", ngot, 1);
    chk("R3 restart value", got[0], 32'h1234);
    clear();
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); afe_frame = 0; afe_nib = 4'hF;
    end
    idle(3);
    chk("R3 stray nibbles ignored", ngot, 0);

    // R4: the unselected source has no effect
    clear();
    lpbk_sel = 1;
    send_word(16'h5555);
    idle(3);
    chk("R4 link ignored", ngot, 0);
    lpbk_sel = 0;
    send_lb(16'h1111); send_lb(16'h2222);
    idle(3);
    chk("R4 loopback ignored", ngot, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule